// File: doc/BRIEF.md
# Folding Converter Output Encoder

This block sits behind the comparator bank of a fold-by-four analog-to-digital converter. It turns the raw comparator decisions into an 8-bit binary sample. The fine converter presents a 64-bit cyclic code. Across one fold the lower comparators fill with ones, and across the next fold they empty again while the top comparator stays set. The encoder XORs the top comparator into the lower 63 to unfold this into a thermometer code. An array of three-input gates then turns the thermometer into a one-hot position and suppresses a stray one or zero near the edge. A wired-OR lookup converts that position into six binary bits.

The top comparator provides the seventh bit directly. The most significant bit comes from one of two coarse comparators, which sit a quarter of full scale apart and are centred on mid-scale. The seventh bit chooses between them, so the coarse and fine halves of the result always switch on the same code edge.

Inputs are registered on one edge and the encoded result is registered on the next, which gives a fixed latency of two clocks. A small sequencer drives the valid flag. It has three named states. `PIPE_EMPTY` is entered on reset. The transition *capture* goes to `PIPE_FILL` on the first edge after reset. The transition *deliver* goes to `PIPE_RUN` on the second edge. `PIPE_RUN` then holds until reset.

Top module: `fold_encoder`

## Requirements
- R1: While reset is asserted and before any clock edge after its release, `code` is 0 and `code_vld` is 0.
- R2: `code_vld` is 0 after the first rising edge following reset release. It is 1 from the second edge onward and stays 1 until reset.
- R3: Once `code_vld` is 1, `code` reflects the inputs that were present at the rising edge two edges earlier.
- R4: `code[6]` equals the top comparator `cmp_bus[63]` from that sample, with no filtering.
- R5: The thermometer is bit i = `cmp_bus[i] ^ cmp_bus[63]` for i = 0..62. For a bubble-free thermometer whose ones fill bits 0..k-1, `code[5:0]` = k. In particular, all-zero and all-one comparator buses both give `code[5:0]` = 0.
- R6: A single isolated one at thermometer bit k+1 above a clean edge at k (ones in 0..k-1, zero at k) is ignored, so `code[5:0]` = k.
- R7: When thermometer bits 0..k-1 are one except bit k-2 (k ≥ 2), the result is `code[5:0]` = k-2.
- R8: `code[7]` equals `coarse_hi` when `code[6]` is 1 and `coarse_lo` when `code[6]` is 0. With the coarse thresholds at codes 96 and 160 and an ideal ramp, the output runs through every code 0..255 in order, including the 127 to 128 step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmp_bus | input | 64 | Fine comparator outputs, bit 63 is the top comparator |
| coarse_hi | input | 1 | Coarse comparator set 32 codes above mid-scale |
| coarse_lo | input | 1 | Coarse comparator set 32 codes below mid-scale |
| code | output | 8 | Registered binary sample |
| code_vld | output | 1 | High when `code` carries a captured sample |

## Verification
A clean analog ramp never produces a bubble, so the suppression paths are unreachable from an ideal comparator model. The bench builds the thermometer itself, plants either a stray one just above the edge or a missing one just below the top one, and only then folds it back into cyclic form by XOR with a random top bit. The coarse bits are also drawn independently of the fine code, which forces the MSB steering through combinations that no monotonic input would give.

// File: rtl/fold_enc_pkg.sv
package fold_enc_pkg;

    typedef enum logic [1:0] {
        PIPE_EMPTY = 2'd0,
        PIPE_FILL  = 2'd1,
        PIPE_RUN   = 2'd2
    } pipe_state_t;

endpackage

// File: rtl/fenc_unfold.sv
module fenc_unfold #(
    parameter int CMP_W = 64
) (
    input  logic [CMP_W-1:0] cmp_in,
    output logic [CMP_W-2:0] therm,
    output logic             top_bit
);
    localparam int THERM_W = CMP_W - 1;

    assign top_bit = cmp_in[CMP_W-1];

    generate
        for (genvar i = 0; i < THERM_W; i++) begin : g_xor
            assign therm[i] = cmp_in[i] ^ cmp_in[CMP_W-1];
        end
    endgenerate
endmodule

// File: rtl/fenc_bubble.sv
module fenc_bubble #(
    parameter int CMP_W = 64
) (
    input  logic [CMP_W-2:0] therm,
    output logic [CMP_W-1:0] hot
);
    localparam int THERM_W = CMP_W - 1;
    localparam int EXT_W   = THERM_W + 3;

    // padded view: two ones below bit 0, a zero above the top
    logic [EXT_W-1:0] ext;
    assign ext = {1'b0, therm, 2'b11};

    generate
        for (genvar j = 0; j < CMP_W; j++) begin : g_term
            assign hot[j] = ext[j] & ext[j+1] & ~ext[j+2];
        end
    endgenerate
endmodule

// File: rtl/fenc_rom.sv
module fenc_rom #(
    parameter int CMP_W = 64,
    parameter int CNT_W = $clog2(CMP_W)
) (
    input  logic [CMP_W-1:0] hot,
    output logic [CNT_W-1:0] cnt
);
    always_comb begin
        cnt = '0;
        for (int j = 0; j < CMP_W; j++) begin
            if (hot[j]) begin
                cnt = cnt | CNT_W'(j);
            end
        end
    end
endmodule

// File: rtl/fenc_seq.sv
module fenc_seq
    import fold_enc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    output logic out_vld
);
    pipe_state_t state_q;
    pipe_state_t state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PIPE_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PIPE_EMPTY: state_d = PIPE_FILL;   // capture
            PIPE_FILL:  state_d = PIPE_RUN;    // deliver
            PIPE_RUN:   state_d = PIPE_RUN;
            default:    state_d = PIPE_EMPTY;
        endcase
    end

    always_comb begin
        unique case (state_q)
            PIPE_RUN: out_vld = 1'b1;
            default:  out_vld = 1'b0;
        endcase
    end
endmodule

// File: rtl/fold_encoder.sv
module fold_encoder #(
    parameter int CMP_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CMP_W-1:0] cmp_bus,
    input  logic             coarse_hi,
    input  logic             coarse_lo,
    output logic [$clog2(CMP_W)+1:0] code,
    output logic             code_vld
);
    localparam int CNT_W   = $clog2(CMP_W);
    localparam int CODE_W  = CNT_W + 2;
    localparam int THERM_W = CMP_W - 1;

    // stage 1: capture
    logic [CMP_W-1:0] cap_cmp;
    logic             cap_hi;
    logic             cap_lo;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_cmp <= '0;
            cap_hi  <= 1'b0;
            cap_lo  <= 1'b0;
        end else begin
            cap_cmp <= cmp_bus;
            cap_hi  <= coarse_hi;
            cap_lo  <= coarse_lo;
        end
    end

    logic [THERM_W-1:0] therm;
    logic               top_bit;
    logic [CMP_W-1:0]   hot;
    logic [CNT_W-1:0]   fine_cnt;
    logic               msb;

    fenc_unfold #(.CMP_W(CMP_W)) u_unfold (
        .cmp_in  (cap_cmp),
        .therm   (therm),
        .top_bit (top_bit)
    );

    fenc_bubble #(.CMP_W(CMP_W)) u_bubble (
        .therm (therm),
        .hot   (hot)
    );

    fenc_rom #(.CMP_W(CMP_W), .CNT_W(CNT_W)) u_rom (
        .hot (hot),
        .cnt (fine_cnt)
    );

    // coarse steering keeps MSB aligned with the fold bit
    assign msb = top_bit ? cap_hi : cap_lo;

    // stage 2: output
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code <= '0;
        end else begin
            code <= {msb, top_bit, fine_cnt};
        end
    end

    fenc_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .out_vld (code_vld)
    );

    logic unused_w;
    assign unused_w = ^CODE_W;
endmodule

// File: rtl/fenc_chk.sv
module fenc_chk #(
    parameter int CMP_W = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CMP_W-1:0] cmp_bus,
    input logic             coarse_hi,
    input logic             coarse_lo,
    input logic [$clog2(CMP_W)+1:0] code,
    input logic             code_vld
);
    localparam int CNT_W  = $clog2(CMP_W);
    localparam int CODE_W = CNT_W + 2;

    AST_VLD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        code_vld |=> code_vld);  // R2

    AST_TOP_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        code_vld |-> code[CODE_W-2] == $past(cmp_bus[CMP_W-1], 2));  // R4

    AST_MSB_STEER: assert property (@(posedge clk) disable iff (!rst_n)
        code_vld |-> code[CODE_W-1] ==
            ($past(cmp_bus[CMP_W-1], 2) ? $past(coarse_hi, 2) : $past(coarse_lo, 2)));  // R8

    AST_FLAT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (code_vld && ($past(cmp_bus, 2) == '0 || $past(cmp_bus, 2) == '1))
            |-> code[CNT_W-1:0] == '0);  // R5
endmodule

bind fold_encoder fenc_chk #(.CMP_W(CMP_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmp_bus   (cmp_bus),
    .coarse_hi (coarse_hi),
    .coarse_lo (coarse_lo),
    .code      (code),
    .code_vld  (code_vld)
);

// File: tb/fold_encoder_tb.sv
module fold_encoder_tb;
    localparam int N = 64;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] cmp_bus = '0;
    logic         coarse_hi = 1'b0;
    logic         coarse_lo = 1'b0;
    logic [7:0]   code;
    logic         code_vld;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [7:0] exp_q [2];
    bit         chk_q [2];
    string      tag_q [2];
    int         nsteps = 0;

    fold_encoder #(.CMP_W(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmp_bus(cmp_bus),
        .coarse_hi(coarse_hi), .coarse_lo(coarse_lo),
        .code(code), .code_vld(code_vld)
    );

    always #4 clk = ~clk;

    task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // cyclic comparator bus from thermometer fill k, top bit, optional bubble
    function automatic logic [N-1:0] mk_cmp(input int k, input bit top, input int mode);
        logic [N-2:0] t;
        for (int i = 0; i < N-1; i++) t[i] = (i < k);
        if (mode == 1) t[k+1] = 1'b1;   // stray one above edge
        if (mode == 2) t[k-2] = 1'b0;   // missing one below top
        return {top, t ^ {(N-1){top}}};
    endfunction

    // drive at this negedge, check output launched two steps earlier
    task automatic step(input logic [N-1:0] c, input logic h, input logic l,
                        input logic [7:0] e, input bit do_chk, input string tag);
        if (nsteps >= 2) check(code_vld == 1'b1, "R2 valid high", {7'd0, code_vld}, 8'd1);
        else             check(code_vld == 1'b0, "R2 valid low", {7'd0, code_vld}, 8'd0);
        if (chk_q[1]) check(code == exp_q[1], tag_q[1], code, exp_q[1]);
        exp_q[1] = exp_q[0]; chk_q[1] = chk_q[0]; tag_q[1] = tag_q[0];
        exp_q[0] = e;        chk_q[0] = do_chk;   tag_q[0] = tag;
        cmp_bus = c; coarse_hi = h; coarse_lo = l;
        nsteps++;
        @(negedge clk);
    endtask

    task automatic ideal(input int c, input string tag);
        int v;
        v = c % 128;
        step(mk_cmp(v % 64, v >= 64, 0), c >= 160, c >= 96, 8'(c), 1, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        chk_q[0] = 0; chk_q[1] = 0;
        void'($urandom(32'h0f01d));
        repeat (3) @(negedge clk);
        check(code == 8'd0, "R1 code in reset", code, 8'd0);
        check(code_vld == 1'b0, "R1 valid in reset", {7'd0, code_vld}, 8'd0);
        rst_n = 1'b1;
        // ramp over every code
        for (int c = 0; c < 256; c++) ideal(c, "R3 R5 R8 ramp");
        // MSB boundary both directions
        ideal(127, "R8 code 127"); ideal(128, "R8 code 128");
        ideal(127, "R8 back to 127"); ideal(96, "R8 lo edge"); ideal(160, "R8 hi edge");
        // flat buses
        step('0, 1'b1, 1'b0, 8'h00, 1, "R5 all zero");
        step('1, 1'b1, 1'b0, 8'hC0, 1, "R4 R5 all one");
        // directed bubbles
        step(mk_cmp(0, 0, 1), 0, 0, 8'd0, 1, "R6 stray at bottom");
        step(mk_cmp(61, 1, 1), 1, 0, {1'b1, 1'b1, 6'd61}, 1, "R6 stray at top");
        step(mk_cmp(2, 0, 2), 0, 1, {1'b1, 1'b0, 6'd0}, 1, "R7 dip low");
        step(mk_cmp(63, 1, 2), 0, 1, {1'b0, 1'b1, 6'd61}, 1, "R7 dip high");
        // random mix
        for (int n = 0; n < 400; n++) begin
            int k, mode, ek;
            bit top, h, l;
            k = int'($urandom % 64);
            top = 1'($urandom); h = 1'($urandom); l = 1'($urandom);
            mode = int'($urandom % 3);
            if (mode == 1 && k > 61) mode = 0;
            if (mode == 2 && k < 2) mode = 0;
            ek = (mode == 2) ? k - 2 : k;
            step(mk_cmp(k, top, mode), h, l, {top ? h : l, top, 6'(ek)}, 1,
                 mode == 1 ? "R6 random" : (mode == 2 ? "R7 random" : "R4 R5 R8 random"));
        end
        step('0, 0, 0, 8'd0, 0, "flush");
        step('0, 0, 0, 8'd0, 0, "flush");
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule